// File: doc/BRIEF.md
# Test-Signal Cross-Correlation Accumulator

This block measures the gain of one feedback DAC unit element in a delta-sigma converter with background calibration. A single-bit pseudo-random test sequence is injected through the unit element under test. The block correlates that test bit with the converter's signed digital output by adding each valid output sample to a running sum, or subtracting it, as the test bit selects. The sign-select multiplexer replaces a multiplier.

Valid samples are counted into fixed sets of `2**SET_LEN_LOG2` samples, and sets are counted into frames of `SETS` sets. When a set closes, the running sum is latched as that unit element's correlation factor and the accumulator restarts from zero. The result of the first set of each frame is also held as the frame's reference correlation, against which a later stage normalises the other factors. The current set index is driven out as the selection code that routes the test bit to the element under test.

Top module: `tsc_top`

## Requirements
- R1: After reset `corrOut`, `refCorr`, `setIdx` and `unitSel` are zero, and `refValid`, `setDone` and `frameDone` are low.
- R2: Each valid sample is added to the running sum when `testBit` is 1 and subtracted from it when `testBit` is 0.
- R3: The accumulator and result width is `SAMPLE_W + SET_LEN_LOG2 + 1` bits, signed. A full set of full-scale samples of one sign, including the most negative code subtracted, gives the exact sum with no wrap.
- R4: A cycle with `sampleValid` low is ignored. It neither changes the sum nor counts toward the set, and `unitSel` holds.
- R5: One cycle after the clock edge that takes the last valid sample of a set, `setDone` is high for exactly one cycle. `corrOut` then equals that set's sum, and `setIdx` equals the index of the set that closed.
- R6: The accumulator restarts from zero at each set, so a set's result depends only on its own samples.
- R7: When set 0 of a frame closes, its result is copied to `refCorr` and `refValid` rises and stays high. The closing of any other set leaves `refCorr` unchanged.
- R8: `unitSel` is the index of the set in progress. It starts at 0, advances by one as each set closes, and returns to 0 after set `SETS-1`.
- R9: `frameDone` pulses for one cycle together with the `setDone` of set `SETS-1`, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Qualifies `sampleData` and `testBit` |
| sampleData | input | SAMPLE_W | Signed converter output sample |
| testBit | input | 1 | Injected test bit: 1 adds, 0 subtracts |
| unitSel | output | SEL_W | Index of the set in progress, used as the unit-element routing code |
| setDone | output | 1 | One-cycle pulse when a set closes |
| setIdx | output | SEL_W | Index of the set that last closed |
| corrOut | output | ACC_W | Correlation factor of the last closed set |
| refCorr | output | ACC_W | Reference correlation taken from set 0 of the frame |
| refValid | output | 1 | High once a reference has been captured |
| frameDone | output | 1 | One-cycle pulse when the last set of a frame closes |

## Verification
A wrong sign choice or a missed clear in the accumulator cannot be seen on the ports until the set closes. It then appears as a wrong `corrOut` within one cycle of the last sample, so every set is checked against a sum that the bench computes on its own. A sample counter that is off by one makes `setDone` arrive a cycle early or late, and the bench watches `setDone` on every sample of every set. A fault in the set counter shows at once in `unitSel`, and a wrong first-set decode shows in `refCorr` at the next set close, and again in the frame's second round.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  // strobes from control to datapath, valid in the cycle they are produced
  typedef struct packed {
    logic accEn;     // a valid sample is present
    logic closeSet;  // this sample is the last of the set
    logic firstSet;  // the set in progress is set 0 of the frame
  } tsc_ctrl_t;
endpackage

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
#(
  parameter int SET_LEN_LOG2 = 18,
  parameter int SETS         = 16,
  localparam int SEL_W       = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sampleValid,
  output tsc_ctrl_t        ctrl,
  output logic [SEL_W-1:0] unitSel,
  output logic             setDone,
  output logic [SEL_W-1:0] setIdx,
  output logic             frameDone
);
  logic [SET_LEN_LOG2-1:0] sampleCnt;
  logic [SEL_W-1:0]        setCnt;
  logic                    lastSample;
  logic                    lastSet;

  assign lastSample = sampleValid && (&sampleCnt);
  assign lastSet    = (setCnt == SEL_W'(SETS - 1));

  always_comb begin
    ctrl.accEn    = sampleValid;
    ctrl.closeSet = lastSample;
    ctrl.firstSet = (setCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sampleCnt <= '0;
      setCnt    <= '0;
      setDone   <= 1'b0;
      setIdx    <= '0;
      frameDone <= 1'b0;
    end else begin
      setDone   <= lastSample;
      frameDone <= lastSample && lastSet;
      if (sampleValid) sampleCnt <= sampleCnt + 1'b1;
      if (lastSample) begin
        setIdx <= setCnt;
        setCnt <= lastSet ? '0 : setCnt + 1'b1;
      end
    end
  end

  assign unitSel = setCnt;
endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int SAMPLE_W     = 17,
  parameter int SET_LEN_LOG2 = 18,
  localparam int ACC_W       = SAMPLE_W + SET_LEN_LOG2 + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tsc_ctrl_t           ctrl,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                testBit,
  output logic [ACC_W-1:0]    corrOut,
  output logic [ACC_W-1:0]    refCorr,
  output logic                refValid
);
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] sampleExt;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] accNext;

  // sign-extend before negating so the most negative code negates exactly
  assign sampleExt = ACC_W'($signed(sampleData));
  assign term      = testBit ? sampleExt : -sampleExt;
  assign accNext   = acc + term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      corrOut  <= '0;
      refCorr  <= '0;
      refValid <= 1'b0;
    end else if (ctrl.closeSet) begin
      acc     <= '0;
      corrOut <= accNext;
      if (ctrl.firstSet) begin
        refCorr  <= accNext;
        refValid <= 1'b1;
      end
    end else if (ctrl.accEn) begin
      acc <= accNext;
    end
  end
endmodule

// File: rtl/tsc_top.sv
module tsc_top
  import tsc_pkg::*;
#(
  parameter int SAMPLE_W     = 17,
  parameter int SET_LEN_LOG2 = 18,
  parameter int SETS         = 16,
  localparam int SEL_W       = $clog2(SETS),
  localparam int ACC_W       = SAMPLE_W + SET_LEN_LOG2 + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                testBit,
  output logic [SEL_W-1:0]    unitSel,
  output logic                setDone,
  output logic [SEL_W-1:0]    setIdx,
  output logic [ACC_W-1:0]    corrOut,
  output logic [ACC_W-1:0]    refCorr,
  output logic                refValid,
  output logic                frameDone
);
  tsc_ctrl_t ctrl;

  tsc_ctrl #(.SET_LEN_LOG2(SET_LEN_LOG2), .SETS(SETS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .ctrl(ctrl),
    .unitSel(unitSel), .setDone(setDone), .setIdx(setIdx), .frameDone(frameDone)
  );

  tsc_datapath #(.SAMPLE_W(SAMPLE_W), .SET_LEN_LOG2(SET_LEN_LOG2)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .sampleData(sampleData),
    .testBit(testBit), .corrOut(corrOut), .refCorr(refCorr), .refValid(refValid)
  );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int SETS   = 16,
  parameter int ACC_W  = 36,
  localparam int SEL_W = $clog2(SETS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sampleValid,
  input logic [SEL_W-1:0] unitSel,
  input logic             setDone,
  input logic [SEL_W-1:0] setIdx,
  input logic [ACC_W-1:0] refCorr,
  input logic             refValid,
  input logic             frameDone
);
  // R5: the set-close pulse lasts one cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    setDone |=> !setDone);

  // R8: the closed set's index is the selection code that was in use
  p_idx_matches_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    setDone |-> (setIdx == $past(unitSel)));

  // R4: with no valid sample the selection code holds
  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> $stable(unitSel));

  // R9: frame end only with the close of the last set
  p_frame_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> (setDone && setIdx == SEL_W'(SETS - 1)));

  // R7: reference changes only when set 0 closes
  p_ref_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(setDone && setIdx == '0) |-> $stable(refCorr));

  // R7: once captured the reference stays valid
  p_ref_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refValid |=> refValid);
endmodule

bind tsc_top tsc_checker #(.SETS(SETS), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .unitSel(unitSel),
  .setDone(setDone), .setIdx(setIdx), .refCorr(refCorr), .refValid(refValid),
  .frameDone(frameDone)
);

// File: tb/tsc_top_tb.sv
module tsc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW   = 17;
  localparam int LG   = 3;
  localparam int NS   = 4;
  localparam int SL   = 1 << LG;
  localparam int SELW = $clog2(NS);
  localparam int AW   = SW + LG + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleValid = 1'b0;
  logic [SW-1:0] sampleData = '0;
  logic testBit = 1'b0;
  logic [SELW-1:0] unitSel, setIdx;
  logic setDone, refValid, frameDone;
  logic [AW-1:0] corrOut, refCorr;

  int checks = 0;
  int failures = 0;
  int expSel = 0;
  longint refExp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsc_top #(.SAMPLE_W(SW), .SET_LEN_LOG2(LG), .SETS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleData(sampleData),
    .testBit(testBit), .unitSel(unitSel), .setDone(setDone), .setIdx(setIdx),
    .corrOut(corrOut), .refCorr(refCorr), .refValid(refValid), .frameDone(frameDone)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [AW-1:0] v);
    return longint'($signed(v));
  endfunction

  // sample value and test bit for each pattern
  function automatic longint patVal(input int mode, input int i);
    case (mode)
      0: return longint'(i * 37 - 100);
      1: return 65535;
      2: return -65536;
      default: return longint'((i % 3) * 5000 - 4000);
    endcase
  endfunction

  function automatic logic patBit(input int mode, input int i);
    case (mode)
      0: return logic'(i % 2);
      1: return 1'b1;
      2: return 1'b0;
      default: return logic'((i / 2) % 2);
    endcase
  endfunction

  // feeds one whole set; gaps inserts invalid cycles carrying garbage (R4)
  task automatic runSet(input int mode, input bit gaps, input string tag);
    longint sum = 0;
    for (int i = 0; i < SL; i++) begin
      if (gaps) begin
        sampleValid = 1'b0; sampleData = SW'(-30000); testBit = 1'b1;
        @(posedge clk); @(negedge clk);
        check({tag, " R4 no close on invalid"}, setDone, 0);
        check({tag, " R4 sel holds"}, unitSel, expSel);
      end
      sampleValid = 1'b1;
      sampleData = SW'(patVal(mode, i));
      testBit = patBit(mode, i);
      sum += testBit ? patVal(mode, i) : -patVal(mode, i);
      @(posedge clk); @(negedge clk);
      sampleValid = 1'b0;
      if (i < SL - 1) check({tag, " R5 no early close"}, setDone, 0);
    end
    check({tag, " R5 setDone"}, setDone, 1);
    check({tag, " R2 R3 R6 corrOut"}, sx(corrOut), sum);
    check({tag, " R5 setIdx"}, setIdx, expSel);
    check({tag, " R9 frameDone"}, frameDone, (expSel == NS - 1) ? 1 : 0);
    if (expSel == 0) refExp = sum;
    check({tag, " R7 refCorr"}, sx(refCorr), refExp);
    check({tag, " R7 refValid"}, refValid, 1);
    expSel = (expSel + 1) % NS;
    check({tag, " R8 unitSel"}, unitSel, expSel);
    @(posedge clk); @(negedge clk);
    check({tag, " R5 pulse ends"}, setDone, 0);
    check({tag, " R9 pulse ends"}, frameDone, 0);
  endtask

  task automatic testReset();
    check("R1 corrOut", corrOut, 0);
    check("R1 refCorr", refCorr, 0);
    check("R1 refValid", refValid, 0);
    check("R1 setDone", setDone, 0);
    check("R1 frameDone", frameDone, 0);
    check("R1 unitSel", unitSel, 0);
    check("R1 setIdx", setIdx, 0);
  endtask

  task automatic testFrame();
    runSet(0, 1'b0, "frame1 set0 mixed");
    runSet(1, 1'b0, "frame1 set1 max positive");
    runSet(2, 1'b0, "frame1 set2 most negative");
    runSet(3, 1'b1, "frame1 set3 gaps");
  endtask

  task automatic testSecondFrame();
    runSet(3, 1'b1, "frame2 set0 new ref");
    runSet(0, 1'b1, "frame2 set1");
    runSet(2, 1'b0, "frame2 set2");
    runSet(1, 1'b0, "frame2 set3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testFrame();
    testSecondFrame();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule